// File: doc/BRIEF.md
# Transceiver Control and Fault-Status Register Block

This block is the device-side register file of a line transceiver. It holds an 8-bit mode register and an 8-bit interrupt status register, and it drives an active-high interrupt request. The mode register has a software reset bit, a wake-up interrupt enable, a regulator undervoltage-output enable and a regulator disable bit. Its four middle bits are read-only and show live fault conditions: a fault on the data-out driver, a fault on the C/Q driver, supply undervoltage and over-temperature.

Each raw condition input is registered once. The registered copy is the live status bit, which follows the condition in both directions. A rising edge of the condition also sets a sticky flag in the status register. A read of the status register clears the flags. The interrupt request is high while any flag is set. A wake-up detector counts consecutive cycles in which the wake input is high while the C/Q driver is enabled. When the count reaches the threshold it produces a one-cycle wake pulse. The pulse does not depend on the enable bit; the wake flag is set only when the enable bit is set. While the software reset bit is 1, all flags are held clear and no interrupt can be raised.

Top module: `ctl_stat_regs`

## Requirements
- R1: After the reset input is released, the mode register reads 0x00 (with all conditions low), the status register reads 0x00, and irq_o, wake_pulse_o, ldo_uv_o and ldo_off_o are all low.
- R2: A write to address 1 (mode) with bit 7 = 0 loads bit 7 = soft reset, bit 6 = wake enable, bit 1 = undervoltage-output enable and bit 0 = regulator off. Read bits 5..2 always show the live conditions and are not changed by the written data.
- R3: A mode write with bit 7 = 1 sets the soft reset bit and clears bits 6, 1 and 0 and every status flag in the same edge. While soft reset is 1, the flags stay 0 and irq_o stays low. A later write with bit 7 = 0 restores normal flag setting.
- R4: Live mode bits 5, 4, 3 and 2 equal the data-out fault, C/Q fault, supply undervoltage and over-temperature inputs sampled at the previous clock edge. A rising edge of each of these inputs sets status bit 0, 1, 2 and 3 respectively.
- R5: Status flags are sticky. Reading address 0 returns {2'b00, flags} and clears the flags at that edge. A condition that stays high does not set its flag again. irq_o is high exactly when some flag is set.
- R6: When a rising condition edge and a status read fall in the same cycle, the flag is set after that edge; the set wins over the clear.
- R7: When the wake input is high for WAKE_CYC consecutive samples with cq_drv_en_i high, wake_pulse_o is high for exactly one cycle after the WAKE_CYC-th sample, whatever the wake enable. Status bit 4 is set only if wake enable is 1.
- R8: A sample with cq_drv_en_i low or with the wake input low restarts the wake count. A shorter run produces no pulse.
- R9: ldo_uv_o is high exactly when the registered regulator-undervoltage input is high and the undervoltage-output enable is 1. A rising edge of the regulator-undervoltage input sets status bit 5 whatever the enable.
- R10: ldo_off_o equals mode bit 0.
- R11: Status bits 7..6 read 0. Writes to address 0 have no effect. Addresses 2 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Register address (0 status, 1 mode) |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe (a status read clears flags) |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, combinational from the address |
| dq_fault_i | input | 1 | Data-out driver fault condition |
| cq_fault_i | input | 1 | C/Q driver fault condition |
| vsup_uv_i | input | 1 | Supply undervoltage condition |
| hot_i | input | 1 | Over-temperature condition |
| ldo_uv_i | input | 1 | Regulator undervoltage condition |
| wake_det_i | input | 1 | Raw wake-up level |
| cq_drv_en_i | input | 1 | C/Q driver enable, qualifies wake counting |
| irq_o | output | 1 | Interrupt request, OR of status flags |
| wake_pulse_o | output | 1 | One-cycle wake-up pulse |
| ldo_uv_o | output | 1 | Gated regulator undervoltage output |
| ldo_off_o | output | 1 | Regulator disable |

## Verification
Two things can land on the same flag in one cycle: a rising condition edge can coincide with a status read that clears the flags. The bench raises a condition on the same negative edge where it asserts the read strobe. It checks that the read data does not yet show the flag and that the following read does. The second case is a mode write that enters soft reset in the same cycle as a condition edge: the bench requires the flags to be zero, and irq_o low, right after that edge.

// File: rtl/xcvr_csr_pkg.sv
package xcvr_csr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int N_COND = 5;
  localparam int N_FLAG = 6;

  localparam logic [AW-1:0] ADR_STAT = 2'd0;
  localparam logic [AW-1:0] ADR_MODE = 2'd1;

  localparam int C_DQ   = 0;
  localparam int C_CQ   = 1;
  localparam int C_VSUP = 2;
  localparam int C_HOT  = 3;
  localparam int C_LDO  = 4;

  localparam int F_WAKE = 4;
  localparam int F_LDO  = 5;

  localparam int B_SRST = 7;
  localparam int B_WIE  = 6;
  localparam int B_UVEN = 1;
  localparam int B_OFF  = 0;

  function automatic logic [N_COND-1:0] rise_of(input logic [N_COND-1:0] now,
                                                input logic [N_COND-1:0] prev);
    return now & ~prev;
  endfunction

  function automatic logic [N_FLAG-1:0] flag_set_vec(input logic [N_COND-1:0] rise,
                                                     input logic wake);
    return {rise[C_LDO], wake, rise[C_HOT], rise[C_VSUP], rise[C_CQ], rise[C_DQ]};
  endfunction

  function automatic logic [DW-1:0] pack_mode(input logic srst, input logic wie,
                                              input logic [N_COND-1:0] live,
                                              input logic uven, input logic off);
    return {srst, wie, live[C_DQ], live[C_CQ], live[C_VSUP], live[C_HOT], uven, off};
  endfunction
endpackage

// File: rtl/cond_track.sv
module cond_track #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] live_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_o[i] <= 1'b0;
      else        live_o[i] <= cond_i[i];
    end
  end

  assign rise_o = xcvr_csr_pkg::rise_of(cond_i, live_o);
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic en_i,
  output logic evt_o,
  output logic pulse_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(CYC);

  logic          qual;
  logic [CW-1:0] cnt_q;

  assign qual  = det_i & en_i;
  assign evt_o = qual && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= evt_o;
      if (!qual)            cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_clr_i,
  input  logic         rd_clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[i] <= 1'b0;
      else if (hold_clr_i) flags_o[i] <= 1'b0;
      else                 flags_o[i] <= (flags_o[i] & ~rd_clr_i) | set_i[i];
    end
  end

  assign irq_o = |flags_o;
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          srst_o,
  output logic          wie_o,
  output logic          uven_o,
  output logic          off_o,
  output logic          enter_rst_o
);
  import xcvr_csr_pkg::*;

  assign enter_rst_o = wr_i & wdata_i[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_o <= 1'b0;
      wie_o  <= 1'b0;
      uven_o <= 1'b0;
      off_o  <= 1'b0;
    end else if (enter_rst_o) begin
      srst_o <= 1'b1;
      wie_o  <= 1'b0;
      uven_o <= 1'b0;
      off_o  <= 1'b0;
    end else if (wr_i) begin
      srst_o <= 1'b0;
      wie_o  <= wdata_i[B_WIE];
      uven_o <= wdata_i[B_UVEN];
      off_o  <= wdata_i[B_OFF];
    end
  end
endmodule

// File: rtl/ctl_stat_regs.sv
module ctl_stat_regs #(
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] csr_addr,
  input  logic       csr_wr,
  input  logic       csr_rd,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  input  logic       dq_fault_i,
  input  logic       cq_fault_i,
  input  logic       vsup_uv_i,
  input  logic       hot_i,
  input  logic       ldo_uv_i,
  input  logic       wake_det_i,
  input  logic       cq_drv_en_i,
  output logic       irq_o,
  output logic       wake_pulse_o,
  output logic       ldo_uv_o,
  output logic       ldo_off_o
);
  import xcvr_csr_pkg::*;

  logic [N_COND-1:0] cond_raw;
  logic [N_COND-1:0] live_q;
  logic [N_COND-1:0] rise_w;
  logic [N_FLAG-1:0] flags_q;
  logic [N_FLAG-1:0] set_w;
  logic              srst_q, wie_q, uven_q, off_q;
  logic              enter_rst, hold_clr;
  logic              mode_wr, status_rd;
  logic              wake_evt;

  assign cond_raw = {ldo_uv_i, hot_i, vsup_uv_i, cq_fault_i, dq_fault_i};

  assign mode_wr   = csr_wr && (csr_addr == ADR_MODE);
  assign status_rd = csr_rd && (csr_addr == ADR_STAT);

  cond_track #(.N(N_COND)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_raw),
    .live_o (live_q),
    .rise_o (rise_w)
  );

  wake_qual #(.CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .det_i   (wake_det_i),
    .en_i    (cq_drv_en_i),
    .evt_o   (wake_evt),
    .pulse_o (wake_pulse_o)
  );

  mode_ctl #(.DW(DW)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (mode_wr),
    .wdata_i     (csr_wdata),
    .srst_o      (srst_q),
    .wie_o       (wie_q),
    .uven_o      (uven_q),
    .off_o       (off_q),
    .enter_rst_o (enter_rst)
  );

  assign hold_clr = srst_q | enter_rst;
  assign set_w    = flag_set_vec(rise_w, wake_evt & wie_q);

  irq_flags #(.N(N_FLAG)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_clr_i (hold_clr),
    .rd_clr_i   (status_rd),
    .set_i      (set_w),
    .flags_o    (flags_q),
    .irq_o      (irq_o)
  );

  assign ldo_uv_o  = live_q[C_LDO] & uven_q;
  assign ldo_off_o = off_q;

  always_comb begin
    unique case (csr_addr)
      ADR_STAT: csr_rdata = {{(DW-N_FLAG){1'b0}}, flags_q};
      ADR_MODE: csr_rdata = pack_mode(srst_q, wie_q, live_q, uven_q, off_q);
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctl_stat_regs_chk.sv
module ctl_stat_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst,
  input logic       enter_rst,
  input logic [5:0] flags,
  input logic       irq,
  input logic [4:0] live,
  input logic [4:0] cond_raw,
  input logic [4:0] rise,
  input logic       status_rd,
  input logic       wake_evt,
  input logic       wake_ie,
  input logic       wake_pulse,
  input logic       uv_en,
  input logic       ldo_uv_out
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (flags == 6'd0 && !irq));                                    // R3
  AST_LIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (live == $past(cond_raw)));                                  // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !status_rd && !srst && !enter_rst) |=> flags[1]);        // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && status_rd && !srst && !enter_rst) |=> flags[0]);          // R6
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wake_pulse);                                             // R7
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_ie && !flags[4]) |=> !flags[4]);                               // R7
  AST_UV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_en |-> !ldo_uv_out);                                              // R9
  AST_LDO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[4] && !srst && !enter_rst) |=> flags[5]);                       // R9
endmodule

bind ctl_stat_regs ctl_stat_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst       (srst_q),
  .enter_rst  (enter_rst),
  .flags      (flags_q),
  .irq        (irq_o),
  .live       (live_q),
  .cond_raw   (cond_raw),
  .rise       (rise_w),
  .status_rd  (status_rd),
  .wake_evt   (wake_evt),
  .wake_ie    (wie_q),
  .wake_pulse (wake_pulse_o),
  .uv_en      (uven_q),
  .ldo_uv_out (ldo_uv_o)
);

// File: tb/test_ctl_stat_regs.sv
module test_ctl_stat_regs;
  localparam int WC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] csr_addr = '0;
  logic       csr_wr = 1'b0, csr_rd = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       dq = 0, cq = 0, vs = 0, hot = 0, luv = 0, wake = 0, cqen = 0;
  logic       irq, wpulse, uvo, off;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctl_stat_regs #(.WAKE_CYC(WC)) i_ctl_stat_regs (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dq_fault_i(dq), .cq_fault_i(cq),
    .vsup_uv_i(vs), .hot_i(hot), .ldo_uv_i(luv), .wake_det_i(wake), .cq_drv_en_i(cqen),
    .irq_o(irq), .wake_pulse_o(wpulse), .ldo_uv_o(uvo), .ldo_off_o(off)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    tick();
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    csr_addr = a; csr_rd = 1'b1;
    #1 d = csr_rdata;
    tick();
    csr_rd = 1'b0;
  endtask

  task automatic set_cond(input logic [4:0] p);
    {luv, hot, vs, cq, dq} = p;
  endtask

  function automatic logic [7:0] flmap(input logic [4:0] x);
    return {2'b00, x[4], 1'b0, x[3:0]};
  endfunction

  function automatic logic [7:0] livemap(input logic [4:0] x);
    return {2'b00, x[0], x[1], x[2], x[3], 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, exp, exp_fl;
    logic [4:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(2'd1, got); chk("R1 mode", got, 8'h00);
    rd(2'd0, got); chk("R1 status", got, 8'h00);
    chk("R1 outputs", {irq, wpulse, uvo, off}, 4'b0000);

    // R2 / R3 / R10: sweep every mode write value with fixed live conditions
    set_cond(5'b01001); tick();
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      rd(2'd1, got);
      exp = v[7] ? (8'h80 | livemap(5'b01001))
                 : ({v[7:6], 6'b0} | livemap(5'b01001) | 8'(v[1:0]));
      chk("R2 mode sweep", got, exp);
      chk("R10 ldo_off", off, v[7] ? 1'b0 : v[0]);
      if (v[7]) chk("R3 quiet in soft reset", {irq, 6'(0)}, 7'd0);
    end
    wr(2'd1, 8'h00);

    // R4 / R5 / R9: sweep every condition pattern, two passes with uv enable on/off
    set_cond(5'b0); tick();
    rd(2'd0, got);
    exp_fl = 8'h00; prev = 5'b0;
    for (int pass = 0; pass < 2; pass++) begin
      wr(2'd1, pass == 0 ? 8'h02 : 8'h00);
      for (int p = 0; p < 32; p++) begin
        set_cond(5'(p)); tick();
        exp_fl = exp_fl | flmap(5'(p) & ~prev);
        prev = 5'(p);
        rd(2'd1, got);
        chk("R4 live bits", got, livemap(5'(p)) | (pass == 0 ? 8'h02 : 8'h00));
        chk("R9 uv output", uvo, (pass == 0) & p[4]);
        chk("R5 irq", irq, exp_fl != 0);
        if (p % 4 == 3) begin
          rd(2'd0, got); chk("R5 status read", got, exp_fl);
          exp_fl = 8'h00;
        end
      end
    end
    rd(2'd0, got);

    // R5 persisting condition does not re-set after clear
    set_cond(5'b0); tick();
    rd(2'd0, got);
    dq = 1; tick();
    rd(2'd0, got); chk("R5 flag set", got, 8'h01);
    rd(2'd0, got); chk("R5 no re-set while held", got, 8'h00);
    chk("R5 irq low after clear", irq, 1'b0);

    // R6 set and read in the same cycle
    dq = 0; tick();
    dq = 1;
    rd(2'd0, got); chk("R6 read before set", got, 8'h00);
    rd(2'd0, got); chk("R6 set wins", got, 8'h01);

    // R3 soft reset holds flags clear; release restores
    set_cond(5'b0); tick(); rd(2'd0, got);
    wr(2'd1, 8'h43);
    hot = 1; tick();
    chk("R3 flag before reset", irq, 1'b1);
    hot = 0;
    wr(2'd1, 8'h80);
    rd(2'd0, got); chk("R3 status cleared", got, 8'h00);
    rd(2'd1, got); chk("R3 controls cleared", got, 8'h80);
    hot = 1; tick(); hot = 0; tick(); hot = 1; tick();
    rd(2'd0, got); chk("R3 no flag in reset", got, 8'h00);
    chk("R3 irq low", irq, 1'b0);
    hot = 0; wr(2'd1, 8'h00);
    hot = 1; tick();
    rd(2'd0, got); chk("R3 resume", got, 8'h08);
    hot = 0;
    // R3 enter reset on the same edge as a condition edge
    tick();
    dq = 1; wr(2'd1, 8'h80);
    chk("R3 same-edge entry", {irq, csr_rdata}, {1'b0, 8'h80 | livemap(5'b00001)});
    dq = 0; wr(2'd1, 8'h00);

    // R11 status bits, writes ignored, unmapped addresses
    luv = 1; tick(); luv = 0;
    wr(2'd0, 8'hFF);
    rd(2'd0, got); chk("R11 status write ignored", got, 8'h20);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hC3);
    rd(2'd1, got); chk("R11 unmapped write", got, 8'h00);
    rd(2'd2, got); chk("R11 addr2 reads 0", got, 8'h00);
    rd(2'd3, got); chk("R11 addr3 reads 0", got, 8'h00);

    // R7 wake pulse, enable off then on
    cqen = 1;
    for (int ie = 0; ie < 2; ie++) begin
      wr(2'd1, ie == 1 ? 8'h40 : 8'h00);
      rd(2'd0, got);
      wake = 1;
      for (int k = 1; k <= WC + 2; k++) begin
        tick();
        chk("R7 pulse timing", wpulse, k == WC);
      end
      wake = 0; tick();
      chk("R7 irq", irq, ie == 1);
      rd(2'd0, got); chk("R7 wake flag", got, ie == 1 ? 8'h10 : 8'h00);
    end

    // R8 short run, disabled driver, interrupted enable
    wake = 1;
    for (int k = 0; k < WC - 1; k++) begin tick(); chk("R8 short run", wpulse, 1'b0); end
    wake = 0; tick();
    cqen = 0; wake = 1;
    for (int k = 0; k < WC + 2; k++) begin tick(); chk("R8 driver off", wpulse, 1'b0); end
    cqen = 1; wake = 0; tick();
    wake = 1; tick(); tick(); cqen = 0; tick(); cqen = 1;
    for (int k = 0; k < WC - 1; k++) begin tick(); chk("R8 restart", wpulse, 1'b0); end
    tick(); chk("R8 full run after restart", wpulse, 1'b1);
    wake = 0; tick();
    rd(2'd0, got); chk("R8 flag after restart", got, 8'h10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule